// File: doc/BRIEF.md
# Register-Driven SPI Command Engine

This block lets a host on a byte-wide register bus issue short SPI flash commands without driving the serial lines itself. The host first writes the command byte and then its data bytes, one per write, into a transmit register. It packs the write and read byte counts into one length register and sets a start bit in the control register. The engine then drives one SPI mode 0 transaction. Chip select stays low from the first command bit through the last read bit. The bytes received in the read phase are stored, and the host pops them one at a time from a receive register.

A key register arms and disarms the start bit. While the block is disarmed, a start request is dropped and nothing reaches the serial pins. The start bit also serves as the busy flag: it reads as 1 for as long as the transaction runs and clears itself at the end. A second control bit rewinds the buffer pointers without starting anything. A third control bit turns the transaction into a write-only one. The serial clock half-period is a parameter counted in system clock cycles.

Register addresses (parameters, defaults): transmit push 0x90, receive pop 0x91, length 0x92, control 0x93, key 0xB3.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset the engine is disarmed and idle. CS is high, SCLK is low, the control register reads 0x00 and the key register reads 0x00.
- R2: Writing 0x10 to the key register arms the engine and writing 0x00 disarms it. Any other value leaves the state unchanged. A read of the key register returns 0x10 when armed and 0x00 when disarmed.
- R3: A control write with bit 0 set while disarmed is ignored: control bit 0 still reads 0 and CS stays high.
- R4: A control write with bit 0 set while armed and idle starts a transaction. From the next cycle, control bit 0 reads 1 and CS is low. Bit 0 reads 0 again once CS has returned high.
- R5: On MOSI, most significant bit first, the engine sends the command byte and then length[3:0] data bytes, in the order they were pushed. It then sends 0x00 for every read-phase byte, and holds CS low across all of these bytes.
- R6: Unless control bit 2 is set, the read phase lasts length[7:4]+1 bytes (1 to 16). Those received bytes pop from the receive register in arrival order, one per read. When bit 2 is set, the frame ends after the write bytes.
- R7: A control write with bit 1 set and bit 0 clear rewinds the transmit write pointer and the receive read pointer without starting a transaction. The next pushed byte becomes the command byte, and the next pop returns the first received byte.
- R8: SPI mode 0 with SCLK idle low. SCLK is high only while CS is low. MOSI changes only while SCLK is low. Each SCLK half-period lasts CLK_DIV system clock cycles.
- R9: Every started transaction resets both pointers. Bytes pushed after a transaction form the next command from position 0. Pops after a new transaction start from its first received byte, even if the previous response was only partly read.
- R10: Control bits 3 and 4 have no effect on the bytes sent or received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| regWrEn | input | 1 | Register write strobe, one write per cycle |
| regRdEn | input | 1 | Register read strobe; pops the receive register when it addresses it |
| regAddr | input | 8 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Combinational read data for regAddr |
| spiSclk | output | 1 | SPI serial clock |
| spiCsN | output | 1 | SPI chip select, active low |
| spiMosi | output | 1 | SPI data to the flash |
| spiMiso | input | 1 | SPI data from the flash |

## Verification
The hardest case to reach is a transaction that starts while the pointers hold leftovers from earlier traffic. This covers a response read only in part, bytes pushed and then abandoned with the rewind bit, and a push count that fills the whole transmit buffer. The stimulus draws each transaction's data length (including 0 and 15), read length (including 16), write-only flag, spare control bits and the number of bytes popped afterwards from a seeded random source. Each random transaction therefore inherits the pointer state the previous one left. A serial slave model in the bench captures MOSI, supplies MISO and times the SCLK edges against the expected half-period.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  // One length nibble per direction; buffers sized to the largest count.
  localparam int NIB_W = 4;
  localparam int FIFO_DEPTH = 2 ** NIB_W;
  localparam int PTR_W = NIB_W;
  localparam int CNT_W = $clog2(2 * FIFO_DEPTH + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_XFER,
    ST_TAIL
  } engState_t;

  // Strobes from control to datapath, all single-cycle.
  typedef struct packed {
    logic start;     // load command byte, rewind all pointers
    logic clrPtr;    // rewind host-side pointers
    logic txPush;    // store host byte into transmit buffer
    logic rxPop;     // advance receive read pointer
    logic loadNext;  // load next transmit byte into shifter
    logic loadZero;  // load filler byte for read phase
    logic shift;     // advance MOSI by one bit
    logic sample;    // capture one MISO bit
    logic store;     // commit captured byte to receive buffer
  } dpStrobe_t;
endpackage

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter logic [7:0] ADDR_TX = 8'h90,
  parameter logic [7:0] ADDR_RX = 8'h91,
  parameter logic [7:0] ADDR_LEN = 8'h92,
  parameter logic [7:0] ADDR_CTRL = 8'h93,
  parameter logic [7:0] ADDR_LOCK = 8'hB3,
  parameter logic [7:0] KEY_ARM = 8'h10,
  parameter logic [7:0] KEY_DISARM = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWrData,
  input  logic [7:0] rxData,
  output logic [7:0] regRdData,
  output logic       sclk,
  output logic       csN,
  output logic       busy,
  output logic       unlocked,
  output dpStrobe_t  strb
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  engState_t state;
  logic [DIV_W-1:0] divCnt;
  logic [2:0] bitCnt;
  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W-1:0] wrBytes;
  logic [CNT_W-1:0] totalBytes;
  logic [7:0] lenReg;

  logic ctrlWr, go, tick, lastByte, inRead, moreWrite;
  logic [CNT_W-1:0] nextWr, nextRd;

  assign busy = (state != ST_IDLE);
  assign ctrlWr = regWrEn && (regAddr == ADDR_CTRL);
  assign go = ctrlWr && regWrData[0] && unlocked && !busy;
  assign tick = busy && (divCnt == DIV_LAST);
  assign lastByte = (byteCnt == totalBytes - ONE);
  assign inRead = (byteCnt >= wrBytes);
  assign moreWrite = ((byteCnt + ONE) < wrBytes);
  assign nextWr = CNT_W'(lenReg[NIB_W-1:0]) + ONE;
  assign nextRd = regWrData[2] ? '0 : CNT_W'(lenReg[7:NIB_W]) + ONE;

  // Key register and length register.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      unlocked <= 1'b0;
      lenReg <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_LOCK) begin
        if (regWrData == KEY_ARM) unlocked <= 1'b1;
        else if (regWrData == KEY_DISARM) unlocked <= 1'b0;
      end
      if (regAddr == ADDR_LEN) lenReg <= regWrData;
    end
  end

  // Transaction sequencer.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      divCnt <= '0;
      bitCnt <= '0;
      byteCnt <= '0;
      wrBytes <= '0;
      totalBytes <= '0;
      sclk <= 1'b0;
      csN <= 1'b1;
    end else if (go) begin
      state <= ST_LEAD;
      divCnt <= '0;
      bitCnt <= '0;
      byteCnt <= '0;
      wrBytes <= nextWr;
      totalBytes <= nextWr + nextRd;
      sclk <= 1'b0;
      csN <= 1'b0;
    end else begin
      if (busy) divCnt <= tick ? '0 : divCnt + DIV_W'(1);
      unique case (state)
        ST_LEAD: if (tick) state <= ST_XFER;
        ST_XFER: begin
          if (tick) begin
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (bitCnt == 3'd7) begin
                bitCnt <= '0;
                if (lastByte) state <= ST_TAIL;
                else byteCnt <= byteCnt + ONE;
              end else begin
                bitCnt <= bitCnt + 3'd1;
              end
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            state <= ST_IDLE;
            csN <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // Strobes to the datapath.
  always_comb begin
    strb = '0;
    strb.start = go;
    strb.clrPtr = ctrlWr && regWrData[1] && !busy && !go;
    strb.txPush = regWrEn && (regAddr == ADDR_TX) && !busy;
    strb.rxPop = regRdEn && (regAddr == ADDR_RX) && !busy;
    if (state == ST_XFER && tick) begin
      if (!sclk) begin
        strb.sample = 1'b1;
      end else if (bitCnt != 3'd7) begin
        strb.shift = 1'b1;
      end else begin
        strb.store = inRead;
        if (!lastByte) begin
          strb.loadNext = moreWrite;
          strb.loadZero = !moreWrite;
        end
      end
    end
  end

  // Read mux.
  always_comb begin
    if (regAddr == ADDR_RX) regRdData = rxData;
    else if (regAddr == ADDR_LEN) regRdData = lenReg;
    else if (regAddr == ADDR_CTRL) regRdData = {7'd0, busy};
    else if (regAddr == ADDR_LOCK) regRdData = unlocked ? KEY_ARM : KEY_DISARM;
    else regRdData = '0;
  end
endmodule

// File: rtl/spi_cmd_dp.sv
module spi_cmd_dp
  import spi_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strb,
  input  logic [7:0] hostByte,
  input  logic       miso,
  output logic       mosi,
  output logic [7:0] rxData
);
  logic [7:0] txMem [FIFO_DEPTH];
  logic [7:0] rxMem [FIFO_DEPTH];
  logic [PTR_W:0] txWrPtr;  // one extra bit marks a full buffer
  logic [PTR_W-1:0] txRdPtr;
  logic [PTR_W-1:0] rxWrPtr;
  logic [PTR_W-1:0] rxRdPtr;
  logic [7:0] txShift;
  logic [7:0] rxShift;
  logic txFull;

  assign txFull = txWrPtr[PTR_W];
  assign mosi = txShift[7];
  assign rxData = rxMem[rxRdPtr];

  always_ff @(posedge clk) begin
    if (strb.txPush && !txFull) txMem[txWrPtr[PTR_W-1:0]] <= hostByte;
    if (strb.store) rxMem[rxWrPtr] <= rxShift;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txWrPtr <= '0;
      txRdPtr <= '0;
      rxWrPtr <= '0;
      rxRdPtr <= '0;
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strb.start) begin
        txShift <= txMem[0];
        txRdPtr <= PTR_W'(1);
        txWrPtr <= '0;
        rxWrPtr <= '0;
        rxRdPtr <= '0;
      end else begin
        if (strb.clrPtr) begin
          txWrPtr <= '0;
          rxRdPtr <= '0;
        end else begin
          if (strb.txPush && !txFull) txWrPtr <= txWrPtr + 1'b1;
          if (strb.rxPop) rxRdPtr <= rxRdPtr + 1'b1;
        end
        if (strb.loadNext) begin
          txShift <= txMem[txRdPtr];
          txRdPtr <= txRdPtr + 1'b1;
        end else if (strb.loadZero) begin
          txShift <= '0;
        end else if (strb.shift) begin
          txShift <= {txShift[6:0], 1'b0};
        end
        if (strb.sample) rxShift <= {rxShift[6:0], miso};
        if (strb.store) rxWrPtr <= rxWrPtr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter logic [7:0] ADDR_TX = 8'h90,
  parameter logic [7:0] ADDR_RX = 8'h91,
  parameter logic [7:0] ADDR_LEN = 8'h92,
  parameter logic [7:0] ADDR_CTRL = 8'h93,
  parameter logic [7:0] ADDR_LOCK = 8'hB3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       spiSclk,
  output logic       spiCsN,
  output logic       spiMosi,
  input  logic       spiMiso
);
  dpStrobe_t strb;
  logic [7:0] rxData;
  logic busy;
  logic unlocked;

  spi_cmd_ctrl #(
    .CLK_DIV(CLK_DIV),
    .ADDR_TX(ADDR_TX),
    .ADDR_RX(ADDR_RX),
    .ADDR_LEN(ADDR_LEN),
    .ADDR_CTRL(ADDR_CTRL),
    .ADDR_LOCK(ADDR_LOCK)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .regWrEn(regWrEn),
    .regRdEn(regRdEn),
    .regAddr(regAddr),
    .regWrData(regWrData),
    .rxData(rxData),
    .regRdData(regRdData),
    .sclk(spiSclk),
    .csN(spiCsN),
    .busy(busy),
    .unlocked(unlocked),
    .strb(strb)
  );

  spi_cmd_dp u_dp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .hostByte(regWrData),
    .miso(spiMiso),
    .mosi(spiMosi),
    .rxData(rxData)
  );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter logic [7:0] ADDR_CTRL = 8'h93,
  parameter logic [7:0] ADDR_LOCK = 8'hB3
) (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [7:0] regAddr,
  input logic [7:0] regWrData,
  input logic       spiSclk,
  input logic       spiCsN,
  input logic       spiMosi,
  input logic       busy,
  input logic       unlocked
);
  // R8: clock pulses only inside a chip-select window.
  a_r8_sclk_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    spiSclk |-> !spiCsN);

  // R8: data line holds while the clock stays high.
  a_r8_mosi_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    ($past(spiSclk) && spiSclk) |-> $stable(spiMosi));

  // R3: start request while disarmed is dropped.
  a_r3_locked_no_start: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_CTRL && regWrData[0] && !unlocked && !busy)
      |=> (!busy && spiCsN));

  // R4: start request while armed and idle opens a frame.
  a_r4_start_opens_frame: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_CTRL && regWrData[0] && unlocked && !busy)
      |=> (busy && !spiCsN));

  // R2: disarm key takes effect on the next cycle.
  a_r2_disarm: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_LOCK && regWrData == 8'h00) |=> !unlocked);
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(
  .ADDR_CTRL(ADDR_CTRL),
  .ADDR_LOCK(ADDR_LOCK)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .regWrEn(regWrEn),
  .regAddr(regAddr),
  .regWrData(regWrData),
  .spiSclk(spiSclk),
  .spiCsN(spiCsN),
  .spiMosi(spiMosi),
  .busy(busy),
  .unlocked(unlocked)
);

// File: tb/spi_cmd_engine_tb.sv
`timescale 1ns / 1ps
module spi_cmd_engine_tb;
  localparam int DIV = 2;
  localparam logic [7:0] A_TX = 8'h90;
  localparam logic [7:0] A_RX = 8'h91;
  localparam logic [7:0] A_LEN = 8'h92;
  localparam logic [7:0] A_CTRL = 8'h93;
  localparam logic [7:0] A_LOCK = 8'hB3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic regRdEn = 1'b0;
  logic [7:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic spiSclk, spiCsN, spiMosi;
  logic spiMiso = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_cmd_engine #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .spiSclk(spiSclk), .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  // Serial slave model.
  logic [7:0] resp [32];
  logic [7:0] mosiCap [32];
  logic [7:0] capSh, misoSh;
  logic [2:0] bitPos;
  logic [5:0] byteNo;
  int nBits = 0;
  int periodBad = 0;
  time lastRise = 0;

  always @(negedge spiCsN) begin
    nBits = 0; bitPos = 3'd0; byteNo = 6'd0;
    misoSh = resp[0];
    spiMiso = misoSh[7];
  end
  always @(posedge spiSclk) begin
    if (!spiCsN) begin
      if (nBits != 0 && ($time - lastRise) != time'(2 * DIV * 5)) periodBad++;
      lastRise = $time;
      capSh = {capSh[6:0], spiMosi};
      nBits++;
      bitPos = bitPos + 3'd1;
      if (bitPos == 3'd0) begin
        mosiCap[byteNo[4:0]] = capSh;
        byteNo = byteNo + 6'd1;
        misoSh = resp[byteNo[4:0]];
      end else begin
        misoSh = {misoSh[6:0], 1'b0};
      end
    end
  end
  always @(negedge spiSclk) if (!spiCsN) spiMiso = misoSh[7];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic waitIdle();
    logic [7:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(A_CTRL, v);
      if (v[0] == 1'b0) break;
    end
  endtask

  function automatic logic [7:0] expMosi(input int k, input int dataLen, input logic [7:0] tb [16]);
    return (k <= dataLen) ? tb[k] : 8'h00;
  endfunction

  // One full transaction; nPop bytes are popped afterwards.
  task automatic runTxn(input int dataLen, input int rdCnt, input bit noRead,
                        input logic [1:0] spare, input int nPop, input string tag);
    logic [7:0] txB [16];
    logic [7:0] v;
    int total;
    for (int k = 0; k < 16; k++) txB[k] = 8'($urandom);
    for (int k = 0; k < 32; k++) resp[k] = 8'($urandom);
    total = dataLen + 1 + (noRead ? 0 : rdCnt);
    wr(A_LEN, {4'(rdCnt - 1), 4'(dataLen)});
    for (int k = 0; k <= dataLen; k++) wr(A_TX, txB[k]);
    wr(A_CTRL, {3'd0, spare, noRead, 1'b0, 1'b1});
    rd(A_CTRL, v);
    check(v == 8'h01, {"R4 busy after start ", tag}, int'(v), 1);
    waitIdle();
    check(spiCsN == 1'b1, {"R4 frame closed ", tag}, int'(spiCsN), 1);
    check(nBits == 8 * total, {"R6 frame bit count ", tag}, nBits, 8 * total);
    for (int k = 0; k < total; k++) begin
      if (mosiCap[k] != expMosi(k, dataLen, txB))
        check(1'b0, {"R5 mosi byte ", tag}, int'(mosiCap[k]), int'(expMosi(k, dataLen, txB)));
    end
    check(1'b1, {"R5 R10 mosi sequence ", tag}, 0, 0);
    if (!noRead) begin
      for (int k = 0; k < nPop && k < rdCnt; k++) begin
        rd(A_RX, v);
        check(v == resp[dataLen + 1 + k], {"R6 R9 popped byte ", tag},
              int'(v), int'(resp[dataLen + 1 + k]));
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    for (int k = 0; k < 32; k++) resp[k] = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(spiCsN == 1'b1, "R1 cs high", int'(spiCsN), 1);
    check(spiSclk == 1'b0, "R1 sclk low", int'(spiSclk), 0);
    rd(A_CTRL, v); check(v == 8'h00, "R1 ctrl", int'(v), 0);
    rd(A_LOCK, v); check(v == 8'h00, "R1 key", int'(v), 0);

    // R3 start while disarmed
    wr(A_LEN, 8'h00);
    wr(A_TX, 8'h9F);
    wr(A_CTRL, 8'h01);
    rd(A_CTRL, v); check(v == 8'h00, "R3 start ignored", int'(v), 0);
    repeat (20) @(negedge clk);
    check(spiCsN == 1'b1, "R3 cs stays high", int'(spiCsN), 1);

    // R2 key handling
    wr(A_LOCK, 8'h10);
    rd(A_LOCK, v); check(v == 8'h10, "R2 armed", int'(v), 8'h10);
    wr(A_LOCK, 8'h55);
    rd(A_LOCK, v); check(v == 8'h10, "R2 other value ignored", int'(v), 8'h10);
    wr(A_LOCK, 8'h00);
    rd(A_LOCK, v); check(v == 8'h00, "R2 disarmed", int'(v), 0);
    wr(A_LOCK, 8'h10);

    // R7 rewind before a command: stale pushes are discarded
    wr(A_CTRL, 8'h02);  // clear leftover byte from the disarmed attempt
    wr(A_TX, 8'hAA); wr(A_TX, 8'hBB); wr(A_TX, 8'hCC);
    wr(A_CTRL, 8'h02);
    rd(A_CTRL, v); check(v == 8'h00, "R7 rewind does not start", int'(v), 0);
    check(spiCsN == 1'b1, "R7 cs high after rewind", int'(spiCsN), 1);
    runTxn(1, 4, 1'b0, 2'b00, 2, "R7 after rewind");
    wr(A_CTRL, 8'h02);
    rd(A_RX, v); check(v == resp[2], "R7 pop restarts", int'(v), int'(resp[2]));

    // Directed corners: write-only single byte, full buffers
    runTxn(0, 1, 1'b1, 2'b00, 0, "write-only");
    runTxn(15, 16, 1'b0, 2'b11, 16, "max lengths");
    runTxn(0, 16, 1'b0, 2'b01, 3, "single cmd long read");

    // Random mix (partial pops exercise R9 on the next transaction)
    for (int t = 0; t < 24; t++) begin
      runTxn(int'($urandom_range(0, 15)), int'($urandom_range(1, 16)),
             1'($urandom_range(0, 3) == 0), 2'($urandom),
             int'($urandom_range(0, 16)), "random");
    end
    check(periodBad == 0, "R8 sclk half-period", periodBad, 0);

    // Re-disarm: start dropped again
    wr(A_LOCK, 8'h00);
    wr(A_TX, 8'h05);
    wr(A_CTRL, 8'h01);
    rd(A_CTRL, v); check(v == 8'h00, "R3 start ignored after disarm", int'(v), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule